// File: doc/BRIEF.md
# Cascadable FIFO with retransmit

The block is a first-in first-out buffer for 9-bit words, addressed by a write pointer and a read pointer over a word store whose depth is a parameter. A producer writes a word by pulsing an active-low write strobe and a consumer reads by pulsing an active-low read strobe. Both strobes are asynchronous. They pass through a two-stage synchronizer on the system clock, and the block acts on the rising (releasing) edge of each strobe. The output data is valid only while the read strobe is held low. At other times an output-enable flag is deasserted, which stands in for a three-state output. Empty and full flags stop underrun and overrun.

In standalone mode a third flag reports that the buffer is at least half occupied. An active-low retransmit input rewinds the read pointer to location 0 so that stored data can be read out again. The retransmit acts only while both strobes are idle.

In cascade mode several instances share the strobes and the data lines and behave as one deeper buffer. Each instance holds a write token and a read token, or neither. The instance whose first-load input is low at reset holds both tokens. Only the holder of a token acts on the matching strobe. The half-full output is reused as an expansion-out line. It pulses for one clock each time the instance passes a token on, which happens when one of its pointers wraps, and it feeds the expansion-in input of the next instance in a ring.

Top module: `cascade_fifo`

## Requirements
- R1: Words are read out in the order they were written. A write stores `din` when the released write strobe is seen, on the third clock edge after `wr_n` rises. While `rd_n` is held low, `dout` shows the oldest stored word. On the third clock edge after `rd_n` rises, that word is removed.
- R2: While `rst_n` is low, `is_empty` is 1 and `is_full`, `hf_xo` and `dout_oe` are 0. Both pointers return to location 0.
- R3: `dout_oe` is 1 only while the synchronized read strobe is low and the instance may read, meaning standalone mode or holding the read token. While it is 0, `dout` is all zeros. `dout_oe` is 0 from the second clock edge after `rd_n` goes high.
- R4: A write released while `is_full` is 1 is dropped. A read released while `is_empty` is 1 removes nothing. Neither moves a pointer.
- R5: `is_empty` is 1 exactly when 0 words are stored, and `is_full` is 1 exactly when DEPTH words are stored.
- R6: In standalone mode (`cascade_en`=0), `hf_xo` is 1 exactly when at least DEPTH/2 words are stored.
- R7: In standalone mode, a falling edge on `rt_n` while both strobes have been high for at least two synchronized samples sets the read pointer to location 0. The occupancy becomes the write pointer, or DEPTH if the buffer was full. A falling edge on `rt_n` while either strobe is low has no effect.
- R8: In cascade mode `rt_n` has no effect.
- R9: In cascade mode, an instance with `first_n` low at reset starts with both tokens, and one with `first_n` high starts with neither. Strobes are ignored by an instance that lacks the matching token.
- R10: In cascade mode, when a write or read wraps a pointer from DEPTH-1 to 0, the instance gives up that token and drives `hf_xo` high for one clock on the next clock edge. A write hand-off is sent before a read hand-off. When an instance sees `exp_in` high on a clock edge, it takes the write token if it lacks that token and either holds the read token or stores no words. Otherwise it takes the read token.
- R11: A write and a read released on the same clock edge both take effect, and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset, asynchronous assert |
| cascade_en | input | 1 | 1 selects cascade mode, 0 selects standalone |
| first_n | input | 1 | Active-low first-load select, sampled at reset |
| exp_in | input | 1 | Expansion-in token pulse from the previous instance |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low retransmit request |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero while not enabled |
| dout_oe | output | 1 | Output enable, stands in for the three-state drive |
| is_empty | output | 1 | No words stored |
| is_full | output | 1 | DEPTH words stored |
| hf_xo | output | 1 | Half-full in standalone mode, expansion-out pulse in cascade mode |

## Verification
The hardest state to reach is the token hand-off. It needs one instance to fill and wrap its write pointer while a second instance listens on its expansion-in line, and later needs the read pointer to wrap in the same ring. The bench wires two instances in a ring on shared strobes and writes DEPTH plus one words. This shows the last word landing in the second instance. It then reads them back, with a retransmit pulse in the middle that must be ignored, and counts the expansion-out pulses. A second hard case is a retransmit request that arrives while the write strobe is held low. The bench holds the strobe low across the request and confirms that the read order is unchanged.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

  localparam int unsigned CFIFO_WORD_W = 9;

  // Decide which token an expansion-in pulse carries. A trailing read
  // token can only arrive where the writer has already left data or
  // where the writer currently sits.
  function automatic logic take_write_token(input logic has_wtok,
                                            input logic has_rtok,
                                            input logic no_words);
    return !has_wtok && (has_rtok || no_words);
  endfunction

endpackage

// File: rtl/cfifo_strobe_sync.sv
module cfifo_strobe_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prev
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= async_in[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign lvl[i]  = s2_q;
    assign prev[i] = s3_q;
  end

endmodule

// File: rtl/cfifo_store.sv
module cfifo_store #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 2048,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cfifo_ctrl.sv
module cfifo_ctrl
  import cfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cascade_en,
  input  logic          first_n,
  input  logic          exp_in,
  input  logic          w_rise,
  input  logic          r_rise,
  input  logic          rt_fall,
  input  logic          strobes_idle,
  output logic          w_do,
  output logic          r_do,
  output logic          rt_do,
  output logic [AW-1:0] wp,
  output logic [AW-1:0] rp,
  output logic          is_empty,
  output logic          is_full,
  output logic          half,
  output logic          xo,
  output logic          r_ok
);

  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] occ_q, occ_d;
  logic          wtok_q, wtok_d, rtok_q, rtok_d;
  logic          wpend_q, wpend_d, rpend_q, rpend_d;
  logic          xo_q, xo_d;
  logic          w_ok, w_wrap, r_wrap, wq, rq;

  // Flags and qualified events
  always_comb begin
    is_empty = (occ_q == '0);
    is_full  = (occ_q == FULL_C);
    half     = (occ_q >= HALF_C);
    w_ok     = !cascade_en || wtok_q;
    r_ok     = !cascade_en || rtok_q;
    w_do     = w_rise && w_ok && !is_full;
    r_do     = r_rise && r_ok && !is_empty;
    rt_do    = rt_fall && strobes_idle && !cascade_en;
    w_wrap   = w_do && (wp_q == LAST);
    r_wrap   = r_do && (rp_q == LAST);
  end

  // Pointer and occupancy next state
  always_comb begin
    wp_d = wp_q;
    if (w_do) begin
      wp_d = w_wrap ? '0 : wp_q + 1'b1;
    end

    rp_d = rp_q;
    if (rt_do) begin
      rp_d = '0;
    end else if (r_do) begin
      rp_d = r_wrap ? '0 : rp_q + 1'b1;
    end

    if (rt_do) begin
      occ_d = is_full ? FULL_C : {1'b0, wp_q};
    end else begin
      occ_d = occ_q + CW'(w_do) - CW'(r_do);
    end
  end

  // Token and expansion-out next state
  always_comb begin
    wtok_d  = wtok_q;
    rtok_d  = rtok_q;
    wpend_d = 1'b0;
    rpend_d = 1'b0;
    xo_d    = 1'b0;
    wq      = 1'b0;
    rq      = 1'b0;
    if (cascade_en) begin
      if (w_wrap) wtok_d = 1'b0;
      if (r_wrap) rtok_d = 1'b0;
      if (exp_in) begin
        if (take_write_token(wtok_q, rtok_q, is_empty)) begin
          wtok_d = 1'b1;
        end else begin
          rtok_d = 1'b1;
        end
      end
      wq = wpend_q || w_wrap;
      rq = rpend_q || r_wrap;
      if (wq) begin
        xo_d    = 1'b1;
        rpend_d = rq;
      end else if (rq) begin
        xo_d    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      occ_q   <= '0;
      wtok_q  <= !first_n;
      rtok_q  <= !first_n;
      wpend_q <= 1'b0;
      rpend_q <= 1'b0;
      xo_q    <= 1'b0;
    end else begin
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      occ_q   <= occ_d;
      wtok_q  <= wtok_d;
      rtok_q  <= rtok_d;
      wpend_q <= wpend_d;
      rpend_q <= rpend_d;
      xo_q    <= xo_d;
    end
  end

  assign wp = wp_q;
  assign rp = rp_q;
  assign xo = xo_q;

endmodule

// File: rtl/cascade_fifo.sv
module cascade_fifo
  import cfifo_pkg::*;
#(
  parameter int unsigned DATA_W = CFIFO_WORD_W,
  parameter int unsigned DEPTH  = 2048,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cascade_en,
  input  logic              first_n,
  input  logic              exp_in,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rt_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              is_empty,
  output logic              is_full,
  output logic              hf_xo
);

  localparam int unsigned SW = 3;

  logic          rst_s1_q, rst_core_n;
  logic [SW-1:0] s_lvl, s_prev;
  logic          w_rise, r_rise, rt_fall, strobes_idle;
  logic          w_do, r_do, rt_do, half, xo, r_ok;
  logic [AW-1:0] wp, rp;
  logic [DATA_W-1:0] rdata;

  // Reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_core_n <= rst_s1_q;
    end
  end

  cfifo_strobe_sync #(.N(SW)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in ({rt_n, rd_n, wr_n}),
    .lvl      (s_lvl),
    .prev     (s_prev)
  );

  always_comb begin
    w_rise       = s_lvl[0] && !s_prev[0];
    r_rise       = s_lvl[1] && !s_prev[1];
    rt_fall      = !s_lvl[2] && s_prev[2];
    strobes_idle = s_lvl[0] && s_prev[0] && s_lvl[1] && s_prev[1];
  end

  cfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .cascade_en   (cascade_en),
    .first_n      (first_n),
    .exp_in       (exp_in),
    .w_rise       (w_rise),
    .r_rise       (r_rise),
    .rt_fall      (rt_fall),
    .strobes_idle (strobes_idle),
    .w_do         (w_do),
    .r_do         (r_do),
    .rt_do        (rt_do),
    .wp           (wp),
    .rp           (rp),
    .is_empty     (is_empty),
    .is_full      (is_full),
    .half         (half),
    .xo           (xo),
    .r_ok         (r_ok)
  );

  cfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (w_do),
    .waddr (wp),
    .wdata (din),
    .raddr (rp),
    .rdata (rdata)
  );

  always_comb begin
    dout_oe = !s_lvl[1] && r_ok;
    dout    = dout_oe ? rdata : '0;
    hf_xo   = cascade_en ? xo : half;
  end

endmodule

// File: rtl/cfifo_checker.sv
module cfifo_checker #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cascade_en,
  input logic          rd_n,
  input logic          dout_oe,
  input logic          is_empty,
  input logic          is_full,
  input logic          hf_xo,
  input logic          w_do,
  input logic          r_do,
  input logic          rt_do,
  input logic [AW-1:0] wp,
  input logic [AW-1:0] rp
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  a_r1_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    w_do |=> !is_empty);

  a_r3_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && $past(rd_n) && $past(rd_n, 2)) |-> !dout_oe);

  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && !r_do && !rt_do) |=> is_full);

  a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && !w_do && !rt_do) |=> is_empty);

  a_r5_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_empty && is_full));

  a_r7_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    rt_do |=> (rp == '0));

  a_r10_wrap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_en && w_do && (wp == LAST)) |=> hf_xo);

endmodule

bind cascade_fifo cfifo_checker #(.DEPTH(DEPTH)) u_cfifo_checker (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .cascade_en (cascade_en),
  .rd_n       (rd_n),
  .dout_oe    (dout_oe),
  .is_empty   (is_empty),
  .is_full    (is_full),
  .hf_xo      (hf_xo),
  .w_do       (w_do),
  .r_do       (r_do),
  .rt_do      (rt_do),
  .wp         (wp),
  .rp         (rp)
);

// File: tb/test_cascade_fifo.sv
module test_cascade_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int W          = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cas = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] m_dout, p_dout;
  logic m_oe, m_emp, m_full, m_hf;
  logic p_oe, p_emp, p_full, p_hf;
  logic m_xi, p_xi;

  int n_chk = 0;
  int n_fail = 0;
  int xo_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign p_xi = cas && m_hf;
  assign m_xi = cas && p_hf;

  cascade_fifo #(.DATA_W(W), .DEPTH(DEPTH)) i_cascade_fifo (
    .clk(clk), .rst_n(rst_n), .cascade_en(cas), .first_n(1'b0),
    .exp_in(m_xi), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
    .dout(m_dout), .dout_oe(m_oe), .is_empty(m_emp), .is_full(m_full),
    .hf_xo(m_hf)
  );

  cascade_fifo #(.DATA_W(W), .DEPTH(DEPTH)) i_peer (
    .clk(clk), .rst_n(rst_n), .cascade_en(1'b1), .first_n(1'b1),
    .exp_in(p_xi), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
    .dout(p_dout), .dout_oe(p_oe), .is_empty(p_emp), .is_full(p_full),
    .hf_xo(p_hf)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model of the standalone device: queue plus write log
  bit w1, w2, w3, r1, r2, r3, t1, t2, t3;
  logic [W-1:0] q[$];
  logic [W-1:0] logw [DEPTH];
  int wpm;

  always @(posedge clk) begin
    if (!rst_n) begin
      {w1, w2, w3, r1, r2, r3, t1, t2, t3} = '1;
      q.delete();
      wpm = 0;
    end else begin
      bit wr_e, rd_e, rt_e, mfull, mempty;
      wr_e   = w2 && !w3;
      rd_e   = r2 && !r3;
      rt_e   = !t2 && t3 && w2 && w3 && r2 && r3;
      mfull  = (q.size() == DEPTH);
      mempty = (q.size() == 0);
      if (!cas) begin
        if (rt_e) begin
          int n;
          n = mfull ? DEPTH : wpm;
          q.delete();
          for (int i = 0; i < n; i++) q.push_back(logw[i]);
        end else begin
          if (rd_e && !mempty) void'(q.pop_front());
          if (wr_e && !mfull) begin
            q.push_back(din);
            logw[wpm] = din;
            wpm = (wpm + 1) % DEPTH;
          end
        end
      end
      w3 = w2; w2 = w1; w1 = wr_n;
      r3 = r2; r2 = r1; r1 = rd_n;
      t3 = t2; t2 = t1; t1 = rt_n;
    end
  end

  // Compare every clock in standalone mode
  always @(negedge clk) begin
    if (rst_n && !cas) begin
      check("R5 empty flag", m_emp, q.size() == 0);
      check("R5 full flag", m_full, q.size() == DEPTH);
      check("R6 half flag", m_hf, q.size() >= DEPTH / 2);
      check("R3 output enable", m_oe, !r2);
      if (!m_oe) check("R3 idle data", m_dout, 0);
      else if (q.size() > 0) check("R1 read data", m_dout, q[0]);
    end
    if (rst_n && cas && m_hf) xo_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    cas = mode;
    tick(3);
    check("R2 reset empty", m_emp, 1);
    check("R2 reset full", m_full, 0);
    check("R2 reset half", m_hf, 0);
    check("R2 reset oe", m_oe, 0);
    rst_n = 1'b1;
    xo_cnt = 0;
    tick(4);
  endtask

  task automatic wr(input logic [W-1:0] v);
    din = v; wr_n = 1'b0; tick(4); wr_n = 1'b1; tick(4);
  endtask

  task automatic rd(output logic [W-1:0] v);
    rd_n = 1'b0; tick(4);
    v = m_oe ? m_dout : (p_oe ? p_dout : '1);
    rd_n = 1'b1; tick(4);
  endtask

  task automatic rt_pulse();
    rt_n = 1'b0; tick(4); rt_n = 1'b1; tick(4);
  endtask

  initial begin
    logic [W-1:0] v;
    do_reset(1'b0);

    // R1: order of three words
    wr(9'h011); wr(9'h012); wr(9'h013);
    check("R1 not empty after writes", m_emp, 0);
    rd(v); check("R1 first", v, 9'h011);
    rd(v); check("R1 second", v, 9'h012);
    rd(v); check("R1 third", v, 9'h013);

    // R4 and R5: fill, overrun, drain, underrun
    for (int i = 0; i < DEPTH; i++) wr(W'(9'h020 + i));
    check("R5 full after DEPTH writes", m_full, 1);
    wr(9'h099);
    check("R4 still full after dropped write", m_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(v); check("R4 drained word", v, 9'h020 + i);
    end
    check("R5 empty after drain", m_emp, 1);
    rd(v);
    check("R4 empty after dropped read", m_emp, 1);
    wr(9'h030);
    rd(v); check("R4 pointer kept after underrun", v, 9'h030);

    // R7: retransmit, and a request during a held write strobe
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) wr(W'(9'h040 + i));
    rd(v); check("R7 pre read 0", v, 9'h040);
    rd(v); check("R7 pre read 1", v, 9'h041);
    rt_pulse();
    check("R7 half after rewind", m_hf, 1);
    rd(v); check("R7 rewound read", v, 9'h040);
    din = 9'h045; wr_n = 1'b0; tick(4);
    rt_pulse();
    wr_n = 1'b1; tick(4);
    rd(v); check("R7 request ignored while strobe low", v, 9'h041);

    // R11: simultaneous read and write
    do_reset(1'b0);
    wr(9'h050); wr(9'h051);
    din = 9'h052; wr_n = 1'b0; rd_n = 1'b0; tick(4);
    check("R11 data during joint strobe", m_dout, 9'h050);
    wr_n = 1'b1; rd_n = 1'b1; tick(4);
    rd(v); check("R11 next", v, 9'h051);
    rd(v); check("R11 written", v, 9'h052);
    check("R11 empty at end", m_emp, 1);

    // R8 R9 R10: two instances in a ring
    do_reset(1'b1);
    for (int i = 0; i < DEPTH; i++) wr(W'(9'h100 + i));
    check("R9 first device full", m_full, 1);
    check("R9 peer untouched", p_emp, 1);
    check("R10 one pulse after write wrap", xo_cnt, 1);
    wr(W'(9'h100 + DEPTH));
    check("R10 peer took write token", p_emp, 0);
    check("R10 first device still full", m_full, 1);
    rd(v); check("R9 cascade read 0", v, 9'h100);
    rd(v); check("R9 cascade read 1", v, 9'h101);
    rt_pulse();
    for (int i = 2; i < DEPTH; i++) begin
      rd(v); check("R8 retransmit ignored in cascade", v, 9'h100 + i);
    end
    check("R10 two pulses after read wrap", xo_cnt, 2);
    rd(v); check("R10 peer read after hand-off", v, 9'h100 + DEPTH);
    check("R10 peer empty", p_emp, 1);
    check("R10 first device empty", m_emp, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule